// File: doc/BRIEF.md
# SD/MMC Host Command-Line Engine

This block owns the single bidirectional command wire of an SD/MMC host. On a start request it takes a command index, a 32-bit argument and a set of per-command flags. It builds a 48-bit command frame with its CRC7 and shifts it out MSB first. Depending on the flags, it then listens for a short (48-bit) or long (136-bit) reply from the card, checks the reply, and exposes its contents as four 32-bit words. Three sticky flags report the result: reply timeout, CRC mismatch and bad end bit. They stay valid until the next command is accepted.

One engine clock is one card clock. The engine tells the clock gate when the card clock must run through `card_clk_en`. It is high for the whole of a command. It is also high while idle when the free-running option is set, which lets software give a freshly powered card its wake-up clocks. An optional tail of eight clocks with the line released follows a command; software uses it after the command that stops a transfer. The line is launched on the falling clock edge and sampled on the rising one.

Top module: `sdcmd_engine`

## Requirements
- R1: A command frame is 48 bits sent MSB first: 0, 1, the 6-bit index, the 32-bit argument, CRC7 (polynomial x^7+x^3+1, register starting at zero) over those first 40 bits, then 1. Each bit is driven from a falling edge with `cmd_oe` high. Bit 0 follows the rising edge that accepts `start`. Otherwise `cmd_oe` is low and `cmd_out` is 1 (for index 0 with argument 0 the frame is 48'h400000000095).
- R2: `busy` rises on the edge that accepts `start`. When no reply is wanted and no tail is set, it falls on the first rising edge after the last frame bit's clock, so it reads low one cycle after that bit appears.
- R3: With a short reply, 48 bits are captured starting at the first 0 sampled on `cmd_in`. `resp_w0` holds reply bits 39..8, counting bit 47 as the start bit. `resp_w1`..`resp_w3` read zero.
- R4: With the tail option set, `busy` stays high for eight more clocks after the command's last frame or reply bit. During those clocks `card_clk_en` is high and the line is released.
- R5: With a long reply, 136 bits are captured. {`resp_w3`,`resp_w2`,`resp_w1`,`resp_w0`} holds reply bits 127..0: word 0 is the least significant, and its bit 0 is the end bit.
- R6: After the frame, `cmd_in` is sampled on up to 64 rising edges for a start bit, and a start bit on the 64th sample is accepted. If all 64 samples are high, `resp_timeout` is set together with `busy` falling, which happens 64 cycles after it would fall for a command with no reply. The CRC and end-bit flags stay low.
- R7: The reply CRC7 is computed over bits 47..8 for a short reply and bits 127..8 for a long one, and compared with bits 7..1. A mismatch sets `resp_crc_err` unless `skip_crc` was set with the command.
- R8: A reply whose last bit is 0 sets `resp_err`.
- R9: `start` is ignored while `busy` is high: the frame in flight, its flags and its length are unchanged.
- R10: When idle, `card_clk_en` follows `free_clk`.
- R11: During reset `busy`, `cmd_oe` and all flags are 0, `cmd_out` is 1 and all words are zero.
- R12: Accepting a new command clears the three flags and the four words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, equal to the card clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request to issue a command (taken when idle) |
| cmd_idx | input | IDX_W | Command index |
| cmd_arg | input | ARG_W | Command argument |
| want_resp | input | 1 | A reply is expected |
| long_resp | input | 1 | Reply is 136 bits instead of 48 |
| skip_crc | input | 1 | Do not check the reply CRC |
| add_tail | input | 1 | Add eight trailing clocks |
| free_clk | input | 1 | Keep the card clock running while idle |
| cmd_in | input | 1 | Command line as seen from the card |
| cmd_out | output | 1 | Value driven onto the command line |
| cmd_oe | output | 1 | Drive enable for the command line |
| card_clk_en | output | 1 | Card clock gate enable |
| busy | output | 1 | Command in progress |
| resp_timeout | output | 1 | No reply start bit in the window |
| resp_crc_err | output | 1 | Reply CRC mismatch |
| resp_err | output | 1 | Reply end bit was 0 |
| resp_w0 | output | WORD_W | Reply word 0 (least significant) |
| resp_w1 | output | WORD_W | Reply word 1 |
| resp_w2 | output | WORD_W | Reply word 2 |
| resp_w3 | output | WORD_W | Reply word 3 (most significant) |

## Verification
A bit counter that is off by one shows up at once on the wire. The frame gains or loses a bit, the reply words appear shifted by one position, and `busy` falls a cycle early or late; all of this is visible within the first command. A wrong CRC register or a wrong coverage range gives the wrong frame CRC on the first frame, or raises `resp_crc_err` on the first clean reply. A timeout counter that ends one sample early or late is caught by the 64-sample boundary case, where the reply is accepted instead of a timeout being flagged, or the reverse. A state machine that accepts `start` while busy corrupts the frame bits sent after that pulse.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_CHECK,
    ST_TAIL
  } sdcmd_state_t;

  typedef struct packed {
    logic want;
    logic lng;
    logic skip;
    logic tail;
  } sdcmd_cfg_t;

  // one serial step of the x^7 + x^3 + 1 checksum
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction

endpackage

// File: rtl/sdcmd_tx.sv
`timescale 1ns/1ps
module sdcmd_tx #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic             drive,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             cmd_out,
  output logic             cmd_oe
);
  import sdcmd_pkg::*;

  localparam int HDR_W   = IDX_W + ARG_W + 2;
  localparam int FRAME_W = HDR_W + 8;

  logic [HDR_W-1:0]   hdr;
  logic [6:0]         crc;
  logic [FRAME_W-1:0] sh_q, sh_n;

  always_comb begin
    hdr = {1'b0, 1'b1, idx, arg};
    crc = '0;
    for (int i = HDR_W - 1; i >= 0; i--) begin
      crc = crc7_step(crc, hdr[i]);
    end
  end

  always_comb begin
    sh_n = sh_q;
    if (load)       sh_n = {hdr, crc, 1'b1};
    else if (shift) sh_n = {sh_q[FRAME_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_n;
  end

  // launch on the falling edge, half a cycle ahead of the card's sampling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_oe  <= 1'b0;
      cmd_out <= 1'b1;
    end else begin
      cmd_oe  <= drive;
      cmd_out <= drive ? sh_q[FRAME_W-1] : 1'b1;
    end
  end

  AST_LOAD_NOT_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift); // R9

endmodule

// File: rtl/sdcmd_rx.sv
`timescale 1ns/1ps
module sdcmd_rx #(
  parameter int WORD_W  = 32,
  parameter int SHORT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              bit_in,
  input  logic              crc_en,
  input  logic              finish,
  input  logic              long_sel,
  input  logic              skip_crc,
  output logic [WORD_W-1:0] resp_w0,
  output logic [WORD_W-1:0] resp_w1,
  output logic [WORD_W-1:0] resp_w2,
  output logic [WORD_W-1:0] resp_w3,
  output logic              crc_err,
  output logic              end_err
);
  import sdcmd_pkg::*;

  localparam int BODY_W = 4 * WORD_W;

  logic [BODY_W-1:0]          rx_q, rx_n;
  logic [6:0]                 crc_q, crc_n;
  logic [3:0][WORD_W-1:0]     w_q, w_n;
  logic                       crc_err_n, end_err_n;

  always_comb begin
    rx_n      = rx_q;
    crc_n     = crc_q;
    w_n       = w_q;
    crc_err_n = crc_err;
    end_err_n = end_err;
    if (clear) begin
      rx_n      = '0;
      crc_n     = '0;
      w_n       = '0;
      crc_err_n = 1'b0;
      end_err_n = 1'b0;
    end else if (take) begin
      rx_n = {rx_q[BODY_W-2:0], bit_in};
      if (crc_en) crc_n = crc7_step(crc_q, bit_in);
    end else if (finish) begin
      if (long_sel) w_n = rx_q;
      else          w_n = {{(3*WORD_W){1'b0}}, rx_q[SHORT_W-9 -: WORD_W]};
      crc_err_n = !skip_crc && (crc_q != rx_q[7:1]);
      end_err_n = !rx_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      crc_q   <= '0;
      w_q     <= '0;
      crc_err <= 1'b0;
      end_err <= 1'b0;
    end else begin
      rx_q    <= rx_n;
      crc_q   <= crc_n;
      w_q     <= w_n;
      crc_err <= crc_err_n;
      end_err <= end_err_n;
    end
  end

  assign resp_w0 = w_q[0];
  assign resp_w1 = w_q[1];
  assign resp_w2 = w_q[2];
  assign resp_w3 = w_q[3];

  AST_CRC_FLAG_AT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> $past(finish)); // R7
  AST_END_FLAG_AT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_err) |-> $past(finish)); // R8

endmodule

// File: rtl/sdcmd_engine.sv
`timescale 1ns/1ps
module sdcmd_engine #(
  parameter int IDX_W    = 6,
  parameter int ARG_W    = 32,
  parameter int WORD_W   = 32,
  parameter int TMO_CYC  = 64,
  parameter int TAIL_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              want_resp,
  input  logic              long_resp,
  input  logic              skip_crc,
  input  logic              add_tail,
  input  logic              free_clk,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              card_clk_en,
  output logic              busy,
  output logic              resp_timeout,
  output logic              resp_crc_err,
  output logic              resp_err,
  output logic [WORD_W-1:0] resp_w0,
  output logic [WORD_W-1:0] resp_w1,
  output logic [WORD_W-1:0] resp_w2,
  output logic [WORD_W-1:0] resp_w3
);
  import sdcmd_pkg::*;

  localparam int FRAME_W = IDX_W + ARG_W + 10;
  localparam int LONG_W  = 4 * WORD_W + 8;
  localparam int CNT_W   = $clog2(LONG_W);
  localparam int TMO_W   = $clog2(TMO_CYC);
  localparam logic [CNT_W-1:0] FR_LAST   = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LG_LAST   = CNT_W'(LONG_W - 1);
  localparam logic [CNT_W-1:0] TL_LAST   = CNT_W'(TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] S_CRC_HI  = CNT_W'(FRAME_W - 9);
  localparam logic [CNT_W-1:0] L_CRC_LO  = CNT_W'(LONG_W - 4 * WORD_W);
  localparam logic [CNT_W-1:0] L_CRC_HI  = CNT_W'(LONG_W - 9);
  localparam logic [TMO_W-1:0] TMO_LAST  = TMO_W'(TMO_CYC - 1);

  sdcmd_state_t     st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [TMO_W-1:0] tmo_q, tmo_n;
  sdcmd_cfg_t       cfg_q, cfg_n;
  logic             tof_q, tof_n;
  logic             accept, take, crc_en;
  logic [CNT_W-1:0] rx_last;

  assign accept  = (st_q == ST_IDLE) && start;
  assign rx_last = cfg_q.lng ? LG_LAST : FR_LAST;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    tmo_n = tmo_q;
    cfg_n = cfg_q;
    tof_n = tof_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_n       = ST_SEND;
        cnt_n      = '0;
        tof_n      = 1'b0;
        cfg_n.want = want_resp;
        cfg_n.lng  = long_resp;
        cfg_n.skip = skip_crc;
        cfg_n.tail = add_tail;
      end
      ST_SEND: if (cnt_q == FR_LAST) begin
        cnt_n = '0;
        tmo_n = '0;
        if (cfg_q.want)      st_n = ST_WAIT;
        else if (cfg_q.tail) st_n = ST_TAIL;
        else                 st_n = ST_IDLE;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
      ST_WAIT: if (!cmd_in) begin
        st_n  = ST_RECV;
        cnt_n = CNT_W'(1);
      end else if (tmo_q == TMO_LAST) begin
        tof_n = 1'b1;
        cnt_n = '0;
        st_n  = cfg_q.tail ? ST_TAIL : ST_IDLE;
      end else begin
        tmo_n = tmo_q + 1'b1;
      end
      ST_RECV: if (cnt_q == rx_last) st_n = ST_CHECK;
               else                  cnt_n = cnt_q + 1'b1;
      ST_CHECK: begin
        cnt_n = '0;
        st_n  = cfg_q.tail ? ST_TAIL : ST_IDLE;
      end
      ST_TAIL: if (cnt_q == TL_LAST) st_n = ST_IDLE;
               else                  cnt_n = cnt_q + 1'b1;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      tmo_q <= '0;
      cfg_q <= '0;
      tof_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      tmo_q <= tmo_n;
      cfg_q <= cfg_n;
      tof_q <= tof_n;
    end
  end

  assign take   = ((st_q == ST_WAIT) && !cmd_in) || (st_q == ST_RECV);
  assign crc_en = (st_q == ST_RECV) &&
                  (cfg_q.lng ? (cnt_q >= L_CRC_LO && cnt_q <= L_CRC_HI)
                             : (cnt_q <= S_CRC_HI));

  assign busy         = (st_q != ST_IDLE);
  assign card_clk_en  = busy || free_clk;
  assign resp_timeout = tof_q;

  sdcmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .shift   (st_q == ST_SEND),
    .drive   (st_q == ST_SEND),
    .idx     (cmd_idx),
    .arg     (cmd_arg),
    .cmd_out (cmd_out),
    .cmd_oe  (cmd_oe)
  );

  sdcmd_rx #(.WORD_W(WORD_W), .SHORT_W(FRAME_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .take     (take),
    .bit_in   (cmd_in),
    .crc_en   (crc_en),
    .finish   (st_q == ST_CHECK),
    .long_sel (cfg_q.lng),
    .skip_crc (cfg_q.skip),
    .resp_w0  (resp_w0),
    .resp_w1  (resp_w1),
    .resp_w2  (resp_w2),
    .resp_w3  (resp_w3),
    .crc_err  (resp_crc_err),
    .end_err  (resp_err)
  );

  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy); // R1
  AST_TIMEOUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_timeout |-> !(resp_crc_err || resp_err)); // R6
  AST_TIMEOUT_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_timeout) |-> ($past(st_q) == ST_WAIT)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(cfg_q)); // R9
  AST_TAIL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAIL) |-> (!cmd_oe && card_clk_en)); // R4
  AST_IDLE_CLK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !free_clk) |-> !card_clk_en); // R10

endmodule

// File: tb/sdcmd_engine_test.sv
`timescale 1ns/1ps
module sdcmd_engine_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, want_resp, long_resp, skip_crc, add_tail, free_clk, cmd_in;
  logic [5:0]  cmd_idx;
  logic [31:0] cmd_arg;
  logic        cmd_out, cmd_oe, card_clk_en, busy, resp_timeout, resp_crc_err, resp_err;
  logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;

  sdcmd_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .want_resp(want_resp), .long_resp(long_resp), .skip_crc(skip_crc),
    .add_tail(add_tail), .free_clk(free_clk), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .card_clk_en(card_clk_en), .busy(busy),
    .resp_timeout(resp_timeout), .resp_crc_err(resp_crc_err), .resp_err(resp_err),
    .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3)
  );

  int total = 0;
  int bad   = 0;
  logic first_tmo;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic        want;
    logic        lng;
    logic        skip;
    logic        tail;
    logic [1:0]  corrupt;   // 0 clean, 1 wrong CRC, 2 end bit 0
    logic [5:0]  gap;
    logic        exp_crc;
    logic        exp_end;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0,  1'b0, 1'b0},
    '{6'd17, 32'h1234_abcd, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 6'd2,  1'b0, 1'b0},
    '{6'd2,  32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 6'd5,  1'b0, 1'b0},
    '{6'd13, 32'hffff_0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 6'd1,  1'b1, 1'b0},
    '{6'd9,  32'h8000_0001, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 6'd3,  1'b0, 1'b0},
    '{6'd12, 32'ha5a5_5a5a, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 6'd0,  1'b0, 1'b1},
    '{6'd41, 32'h0f0f_0f0f, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 6'd10, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [135:0] act,
                     input logic [135:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c;
    c = '0;
    for (int i = hi; i >= lo; i--) begin
      logic fb;
      fb = c[6] ^ v[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] ref_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {1'b0, 1'b1, idx, arg};
    return {h, ref_crc({96'b0, h}, 39, 0), 1'b1};
  endfunction

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic w,
                       input logic l, input logic s, input logic t,
                       output logic [47:0] got, output bit oe_ok);
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; want_resp = w; long_resp = l;
    skip_crc = s; add_tail = t; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    oe_ok = 1'b1;
    got   = '0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      #1;
      got = {got[46:0], cmd_out};
      if (!cmd_oe) oe_ok = 1'b0;
      if (k == 0) first_tmo = resp_timeout;
    end
  endtask

  task automatic respond(input logic [135:0] bits, input int n, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      cmd_in = 1'b1;
    end
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      cmd_in = bits[i];
    end
    @(negedge clk);
    cmd_in = 1'b1;
  endtask

  task automatic wait_idle(output int n, output bit clk_ok, output bit rel_ok);
    n = 0; clk_ok = 1'b1; rel_ok = 1'b1;
    while (busy && n < 400) begin
      if (!card_clk_en) clk_ok = 1'b0;
      @(negedge clk);
      #1;
      n++;
      if (busy && cmd_oe) rel_ok = 1'b0;
    end
  endtask

  function automatic logic [135:0] make_resp(input vec_t v, output int n);
    logic [135:0] b;
    logic [6:0]   c;
    logic         e;
    b = '0;
    if (v.lng) begin
      n = 136;
      b[135:128] = {2'b00, 6'h3f};
      b[127:8]   = {v.arg, ~v.arg, v.arg ^ 32'h5a5a_5a5a, v.arg[23:0]};
      c = ref_crc(b, 127, 8);
    end else begin
      n = 48;
      b[47:8] = {2'b00, v.idx, v.arg ^ 32'hc3c3_0f0f};
      c = ref_crc(b, 47, 8);
    end
    if (v.corrupt == 2'd1) c = c ^ 7'h01;
    e = (v.corrupt == 2'd2) ? 1'b0 : 1'b1;
    b[7:0] = {c, e};
    return b;
  endfunction

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [47:0]  got;
    logic [135:0] rb;
    logic [127:0] words;
    bit           oe_ok, clk_ok, rel_ok;
    int           n, rl;
    vec_t         v;

    rst_n = 1'b0; start = 1'b0; want_resp = 1'b0; long_resp = 1'b0; skip_crc = 1'b0;
    add_tail = 1'b0; free_clk = 1'b0; cmd_in = 1'b1; cmd_idx = '0; cmd_arg = '0;
    first_tmo = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(!busy && !cmd_oe && cmd_out && !resp_timeout && !resp_crc_err && !resp_err,
        "R11 reset outputs", {busy, cmd_oe, cmd_out, resp_timeout, resp_crc_err, resp_err},
        6'b001000);
    chk({resp_w3, resp_w2, resp_w1, resp_w0} == '0, "R11 reset words",
        {resp_w3, resp_w2, resp_w1, resp_w0}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R1 R2 R3 R5 R7 R8
    for (int vi = 0; vi < NV; vi++) begin
      v = VECS[vi];
      issue(v.idx, v.arg, v.want, v.lng, v.skip, v.tail, got, oe_ok);
      chk(got == ref_frame(v.idx, v.arg), "R1 frame bits", got, ref_frame(v.idx, v.arg));
      chk(oe_ok, "R1 drive enable during frame", oe_ok, 1);
      if (v.want) begin
        rb = make_resp(v, rl);
        respond(rb, rl, v.gap);
        wait_idle(n, clk_ok, rel_ok);
        words = {resp_w3, resp_w2, resp_w1, resp_w0};
        chk(resp_crc_err == v.exp_crc, "R7 crc flag", resp_crc_err, v.exp_crc);
        chk(resp_err == v.exp_end, "R8 end-bit flag", resp_err, v.exp_end);
        chk(!resp_timeout, "R6 no timeout on reply", resp_timeout, 0);
        if (v.lng)
          chk(words == rb[127:0], "R5 long words", words, rb[127:0]);
        else
          chk(words == {96'b0, rb[39:8]}, "R3 short words", words, {96'b0, rb[39:8]});
      end else begin
        wait_idle(n, clk_ok, rel_ok);
        chk(n == (v.tail ? 9 : 1), "R2 busy end", n, v.tail ? 9 : 1);
      end
      repeat (2) @(negedge clk);
    end

    // R1 known frame for index 0, argument 0
    issue(6'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, got, oe_ok);
    chk(got == 48'h4000_0000_0095, "R1 known frame", got, 48'h4000_0000_0095);
    wait_idle(n, clk_ok, rel_ok);
    #1;
    chk(!cmd_oe && cmd_out, "R1 line released", {cmd_oe, cmd_out}, 2'b01);

    // R4 tail clocks
    issue(6'd12, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, got, oe_ok);
    wait_idle(n, clk_ok, rel_ok);
    chk(n == 9, "R4 tail length", n, 9);
    chk(clk_ok, "R4 clock during tail", clk_ok, 1);
    chk(rel_ok, "R4 line released in tail", rel_ok, 1);

    // R6 timeout
    issue(6'd55, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 1'b0, got, oe_ok);
    wait_idle(n, clk_ok, rel_ok);
    chk(n == 65, "R6 timeout busy length", n, 65);
    chk(resp_timeout && !resp_crc_err && !resp_err, "R6 timeout flags",
        {resp_timeout, resp_crc_err, resp_err}, 3'b100);

    // R12 flags cleared at next accepted command
    issue(6'd1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, got, oe_ok);
    chk(first_tmo == 1'b0, "R12 flag cleared on accept", first_tmo, 0);
    wait_idle(n, clk_ok, rel_ok);

    // R6 boundary: start bit on the 64th sample
    v = '{6'd8, 32'h0000_01aa, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0};
    issue(v.idx, v.arg, 1'b1, 1'b0, 1'b0, 1'b0, got, oe_ok);
    rb = make_resp(v, rl);
    respond(rb, rl, 63);
    wait_idle(n, clk_ok, rel_ok);
    chk(!resp_timeout && !resp_crc_err, "R6 64th sample accepted",
        {resp_timeout, resp_crc_err}, 2'b00);
    chk(resp_w0 == rb[39:8], "R6 boundary reply word", resp_w0, rb[39:8]);

    // R9 start while busy
    @(negedge clk);
    cmd_idx = 6'd5; cmd_arg = 32'hcafe_0001; want_resp = 1'b0; long_resp = 1'b0;
    skip_crc = 1'b0; add_tail = 1'b0; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    got = '0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      #1;
      got = {got[46:0], cmd_out};
      if (k == 10) begin
        cmd_idx = 6'd63; cmd_arg = 32'h0; want_resp = 1'b1; add_tail = 1'b1; start = 1'b1;
      end
      if (k == 12) start = 1'b0;
    end
    chk(got == ref_frame(6'd5, 32'hcafe_0001), "R9 frame untouched", got,
        ref_frame(6'd5, 32'hcafe_0001));
    wait_idle(n, clk_ok, rel_ok);
    chk(n == 1, "R9 length untouched", n, 1);

    // R10 idle clock
    @(negedge clk);
    free_clk = 1'b1;
    #1;
    chk(card_clk_en, "R10 free clock idle", card_clk_en, 1);
    @(negedge clk);
    free_clk = 1'b0;
    #1;
    chk(!card_clk_en, "R10 clock stopped idle", card_clk_en, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule